// File: doc/BRIEF.md
# Programmable Up-Counting Timer Channel

This block is one 16-bit timer channel with a small register interface. A setup register holds a power-of-two prescale exponent, a source select that picks between a slow and a fast count strobe, a compare-1 mode, a run bit, two sticky event flags and a read-only "configured" flag. The counter advances once per prescaled tick and returns to zero on the tick after it has matched the wrap comparator (comparator 2). Comparator 1 either flags an exact match or, in threshold mode, drives a pulse-width output that is high while the counter is at or above it.

Both clock domains of the channel are modelled as one-cycle enable strobes on a single clock (`slow_tick`, `fast_tick`). The configuration fields of the setup register take the first write after reset only. Later writes can still start or stop the counter and clear the event flags. Software can tell from the configured flag whether the channel has lost its state. The compare-1 flag, masked by an external enable, forms the interrupt request.

Top module: `gp_timer_chan`

## Requirements
- R1: After reset the setup, counter and comparator registers read 0, `pwm_out` is low and `irq` is low.
- R2: With prescale exponent P in setup bits [3:0], the counter advances once for every 2^P strobes of the selected source.
- R3: Setup bit 4 selects the count source: 1 counts `fast_tick`, 0 counts `slow_tick`. Strobes on the source that is not selected have no effect on the counter.
- R4: On a prescaled tick where the counter equals comparator 2, the counter becomes 0 and the compare-2 flag (setup bit 9) is set.
- R5: In match mode (setup bit 5 = 0), the compare-1 flag (setup bit 8) is set on the tick at which the counter becomes equal to comparator 1, and `pwm_out` stays low.
- R6: In threshold mode (setup bit 5 = 1), `pwm_out` is high exactly while counter >= comparator 1. Comparator 1 = 0 gives a constant high and comparator 1 > comparator 2 gives a constant low. The compare-1 flag is set once the counter reaches the threshold.
- R7: Writing 1 to setup bit 8 or bit 9 clears that flag. Writing 0 leaves it unchanged.
- R8: Setup bit 15 is the run bit. While it is 0 the counter holds its value, and counting resumes from that value when it is set again.
- R9: The first setup write after reset latches bits [5:0]. Later writes leave those bits unchanged, and setup bit 14 reads 1 from the first write on.
- R10: Address 1 holds comparator 1 in data bits [15:0] and comparator 2 in bits [31:16]. `wr_half[0]` and `wr_half[1]` enable the write of each half.
- R11: Address 2 is the counter. A write to it loads the counter with data bits [15:0]. Address 0 is setup (data bits [15:0]).
- R12: `irq` is high exactly when `irq_en` is high and the compare-1 flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow-source count strobe, one cycle wide |
| fast_tick | input | 1 | Fast-source count strobe, one cycle wide |
| irq_en | input | 1 | Interrupt enable for the compare-1 flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 setup, 1 comparators, 2 counter |
| wr_half | input | 2 | Half enables for the comparator write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as the write address |
| rd_data | output | 32 | Read data, combinational from the registers |
| pwm_out | output | 1 | Pulse-width output, active in threshold mode |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a frozen counter that holds a non-zero value with a sticky flag still set, followed by a restart that must continue from the held value. The stimulus drives the counter through a wrap to set the compare-2 flag, clears only compare-1, steps once, drops the run bit and sends strobes into the frozen channel. It then restarts and checks the next value. The write-once lock is covered by a second setup write that carries different configuration bits while the flags and run bit change.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
    localparam int PS_W    = 4;
    localparam int DIV_W   = (1 << PS_W) - 1;
    localparam int SETUP_W = 16;

    // setup register bit positions
    localparam int B_FAST  = PS_W;
    localparam int B_GE    = PS_W + 1;
    localparam int B_EV1   = 8;
    localparam int B_EV2   = 9;
    localparam int B_INIT  = 14;
    localparam int B_RUN   = 15;

    // register addresses
    localparam logic [1:0] A_SETUP = 2'd0;
    localparam logic [1:0] A_CMP   = 2'd1;
    localparam logic [1:0] A_CNT   = 2'd2;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            fast;
        logic            ge;
    } cfg_t;
endpackage

// File: rtl/gpt_prescaler.sv
module gpt_prescaler
    import gpt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic            clr,
    input  logic [PS_W-1:0] ps,
    output logic            ptick
);
    logic [DIV_W-1:0] pre_d, pre_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = (DIV_W'(1) << ps) - DIV_W'(1);
        ptick = go && !clr && (pre_q == mask);
        pre_d = pre_q;
        if (clr)
            pre_d = '0;
        else if (go)
            pre_d = (pre_q == mask) ? '0 : pre_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= mask);
endmodule

// File: rtl/gpt_core.sv
module gpt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] cmp1,
    input  logic [CNT_W-1:0] cmp2,
    input  logic             ge_mode,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap_hit,
    output logic             c1_hit,
    output logic             above
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } core_s;

    core_s s_d, s_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        s_d      = s_q;
        nxt      = (s_q.cnt == cmp2) ? '0 : s_q.cnt + CNT_W'(1);
        wrap_hit = tick && !load && (s_q.cnt == cmp2);
        c1_hit   = tick && !load && (ge_mode ? (nxt >= cmp1) : (nxt == cmp1));
        if (load)
            s_d.cnt = load_val;
        else if (tick)
            s_d.cnt = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt   = s_q.cnt;
    assign above = (s_q.cnt >= cmp1);

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && s_q.cnt == cmp2) |=> (s_q.cnt == '0));

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(s_q.cnt));
endmodule

// File: rtl/gp_timer_chan.sv
module gp_timer_chan
    import gpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               slow_tick,
    input  logic               fast_tick,
    input  logic               irq_en,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [1:0]         wr_half,
    input  logic [2*CNT_W-1:0] wr_data,
    input  logic [1:0]         rd_addr,
    output logic [2*CNT_W-1:0] rd_data,
    output logic               pwm_out,
    output logic               irq
);
    localparam int BUS_W = 2 * CNT_W;

    typedef struct packed {
        cfg_t             cfg;
        logic             run;
        logic             ev1;
        logic             ev2;
        logic             inited;
        logic [CNT_W-1:0] cmp1;
        logic [CNT_W-1:0] cmp2;
    } chan_s;

    chan_s s_d, s_q;

    logic             setup_wr, cnt_wr, src_tick, go, ptick;
    logic             wrap_hit, c1_hit, above;
    logic [CNT_W-1:0] cnt;
    logic [SETUP_W-1:0] setup_view;

    assign setup_wr = wr_en && (wr_addr == A_SETUP);
    assign cnt_wr   = wr_en && (wr_addr == A_CNT);
    assign src_tick = s_q.cfg.fast ? fast_tick : slow_tick;
    assign go       = s_q.run && src_tick;

    gpt_prescaler u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .clr   (cnt_wr),
        .ps    (s_q.cfg.ps),
        .ptick (ptick)
    );

    gpt_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (ptick),
        .load     (cnt_wr),
        .load_val (wr_data[CNT_W-1:0]),
        .cmp1     (s_q.cmp1),
        .cmp2     (s_q.cmp2),
        .ge_mode  (s_q.cfg.ge),
        .cnt      (cnt),
        .wrap_hit (wrap_hit),
        .c1_hit   (c1_hit),
        .above    (above)
    );

    always_comb begin
        s_d = s_q;
        if (setup_wr) begin
            if (!s_q.inited) begin
                s_d.cfg.ps   = wr_data[PS_W-1:0];
                s_d.cfg.fast = wr_data[B_FAST];
                s_d.cfg.ge   = wr_data[B_GE];
                s_d.inited   = 1'b1;
            end
            s_d.run = wr_data[B_RUN];
            if (wr_data[B_EV1]) s_d.ev1 = 1'b0;
            if (wr_data[B_EV2]) s_d.ev2 = 1'b0;
        end
        // a new event wins over a clear in the same cycle
        if (c1_hit)   s_d.ev1 = 1'b1;
        if (wrap_hit) s_d.ev2 = 1'b1;
        if (wr_en && (wr_addr == A_CMP)) begin
            if (wr_half[0]) s_d.cmp1 = wr_data[CNT_W-1:0];
            if (wr_half[1]) s_d.cmp2 = wr_data[BUS_W-1:CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        setup_view                = '0;
        setup_view[PS_W-1:0]      = s_q.cfg.ps;
        setup_view[B_FAST]        = s_q.cfg.fast;
        setup_view[B_GE]          = s_q.cfg.ge;
        setup_view[B_EV1]         = s_q.ev1;
        setup_view[B_EV2]         = s_q.ev2;
        setup_view[B_INIT]        = s_q.inited;
        setup_view[B_RUN]         = s_q.run;
        case (rd_addr)
            A_SETUP: rd_data = BUS_W'(setup_view);
            A_CMP:   rd_data = {s_q.cmp2, s_q.cmp1};
            A_CNT:   rd_data = BUS_W'(cnt);
            default: rd_data = '0;
        endcase
    end

    assign pwm_out = s_q.cfg.ge && above;
    assign irq     = irq_en && s_q.ev1;

    // R7
    ev1_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_wr && wr_data[B_EV1] && !c1_hit) |=> !s_q.ev1);

    // R9
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_wr && s_q.inited) |=> $stable(s_q.cfg));

    // R5
    ev1_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c1_hit |=> s_q.ev1);

    // R4
    ev2_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_hit |=> s_q.ev2);
endmodule

// File: tb/gp_timer_chan_bench.sv
module gp_timer_chan_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0, fast_tick = 1'b0, irq_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0, wr_half = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        pwm_out, irq;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gp_timer_chan u_gp_timer_chan (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
        .irq_en(irq_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_half(wr_half),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_out(pwm_out), .irq(irq)
    );

    // rows: {ps[3:0], fast[3:0], strobes[15:0], expected count[15:0]}
    localparam logic [39:0] VEC [6] = '{
        {4'd0, 4'd0, 16'd5,  16'd5},
        {4'd1, 4'd1, 16'd7,  16'd3},
        {4'd2, 4'd0, 16'd9,  16'd2},
        {4'd3, 4'd1, 16'd16, 16'd2},
        {4'd5, 4'd0, 16'd64, 16'd2},
        {4'd0, 4'd1, 16'd3,  16'd3}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] h, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_half = h; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(input logic fast, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fast) fast_tick = 1'b1; else slow_tick = 1'b1;
            @(negedge clk);
            fast_tick = 1'b0; slow_tick = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        do_reset();
        // R1 reset state
        rd(2'd0, v); check("R1 setup", v, 32'h0);
        rd(2'd1, v); check("R1 cmp", v, 32'h0);
        rd(2'd2, v); check("R1 cnt", v, 32'h0);
        check("R1 pwm", {31'b0, pwm_out}, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 / R3 table walk
        foreach (VEC[k]) begin
            logic [3:0]  ps;
            logic        f;
            logic [15:0] n, e;
            ps = VEC[k][39:36]; f = VEC[k][32]; n = VEC[k][31:16]; e = VEC[k][15:0];
            do_reset();
            wr(2'd1, 2'b10, 32'hFFFF_0000);
            wr(2'd0, 2'b01, 32'h8000 | {27'b0, f, ps});
            pulse(f, int'(n));
            pulse(!f, 5);
            rd(2'd2, v);
            check("R2 R3 prescaled count", v, {16'b0, e});
        end

        // match mode sequence
        do_reset();
        wr(2'd1, 2'b11, {16'd3, 16'd2});
        wr(2'd0, 2'b01, 32'h8000);
        pulse(1'b0, 2);
        rd(2'd0, v); check("R5 ev1 set", v[8], 1'b1);
        check("R5 pwm low in match mode", {31'b0, pwm_out}, 32'h0);
        check("R12 irq high", {31'b0, irq}, 32'h1);
        irq_en = 1'b0; #1;
        check("R12 irq masked", {31'b0, irq}, 32'h0);
        irq_en = 1'b1;
        pulse(1'b0, 1);
        rd(2'd0, v); check("R4 no ev2 before wrap", v[9], 1'b0);
        pulse(1'b0, 1);
        rd(2'd2, v); check("R4 wrap to zero", v, 32'h0);
        rd(2'd0, v); check("R4 ev2 set", v[9], 1'b1);
        wr(2'd0, 2'b01, 32'h8100);
        rd(2'd0, v);
        check("R7 ev1 cleared", v[8], 1'b0);
        check("R7 ev2 kept", v[9], 1'b1);
        check("R9 inited bit", v[14], 1'b1);
        wr(2'd0, 2'b01, 32'h803B);
        rd(2'd0, v); check("R9 config locked", {26'b0, v[5:0]}, 32'h0);
        pulse(1'b0, 1);
        wr(2'd0, 2'b01, 32'h0000);
        pulse(1'b0, 3);
        pulse(1'b1, 3);
        rd(2'd2, v); check("R8 frozen", v, 32'h1);
        wr(2'd0, 2'b01, 32'h8000);
        pulse(1'b0, 1);
        rd(2'd2, v); check("R8 resumes", v, 32'h2);
        wr(2'd2, 2'b01, 32'h0000_0007);
        rd(2'd2, v); check("R11 counter load", v, 32'h7);
        wr(2'd1, 2'b01, 32'h0009_0005);
        rd(2'd1, v); check("R10 low half only", v, 32'h0003_0005);
        wr(2'd1, 2'b10, 32'h0009_0006);
        rd(2'd1, v); check("R10 high half only", v, 32'h0009_0005);

        // threshold mode
        do_reset();
        wr(2'd1, 2'b11, {16'd4, 16'd2});
        wr(2'd0, 2'b01, 32'h8020);
        for (int t = 0; t < 10; t++) begin
            check("R6 pwm level", {31'b0, pwm_out}, {31'b0, (t % 5) >= 2});
            pulse(1'b0, 1);
        end
        rd(2'd0, v); check("R6 ev1 in threshold mode", v[8], 1'b1);
        wr(2'd1, 2'b01, 32'h0);
        for (int t = 0; t < 5; t++) begin
            check("R6 full duty", {31'b0, pwm_out}, 32'h1);
            pulse(1'b0, 1);
        end
        wr(2'd1, 2'b01, 32'h5);
        for (int t = 0; t < 5; t++) begin
            check("R6 zero duty", {31'b0, pwm_out}, 32'h0);
            pulse(1'b0, 1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule